// File: doc/BRIEF.md
# Reseeded Gray-Counter Test Pattern Generator

This block produces deterministic test stimulus for a combinational or full-scan circuit with a wide input vector. It presents one complete pattern on every clock, and no serial shifting happens between patterns. Each pattern subset is described by a seed record. Most inputs stay at constant values that the record supplies, chosen for low leakage. A small window of inputs follows a reflected Gray counter, so only one counted bit toggles from one pattern to the next.

A seed record holds five things: the constant vector, a mask that picks which inputs are counted, a counter-bit selector for each input, a Gray start code, and a run length. Records arrive over a valid/ready handshake. The source can be an on-chip ROM or a slow tester, and it may stall for any number of cycles between records. A start pulse arms the generator. It then takes a record, runs the counter for that record's length, and asks for the next record. The source tags one record as the final one. When that record's run ends, the generator pulses done and returns to idle.

Top module: `gray_tpg`

## Requirements
- R1: After reset, patValid, seedReady and done are all low and pattern is all zeros.
- R2: A start pulse in idle raises seedReady. A record is taken on a clock edge where seedValid and seedReady are both high. From the next cycle patValid is high and the first pattern of the record is on the output.
- R3: Each output bit i equals counter bit sel_i of the current Gray code when mask bit i is 1, and constant bit i when mask bit i is 0. The selector sel_i is the field seedSel[i*IDX_W +: IDX_W].
- R4: The counter code is the reflected Gray code g = b ^ (b >> 1) of a binary count b, and b increments by one on each pattern. Consecutive codes within a run therefore differ in exactly one bit.
- R5: The first pattern of a record uses the record's Gray start code. After code 1000 (for a 4-bit counter) the counter wraps to 0000.
- R6: A record whose length field is L produces exactly L+1 valid patterns, so L = 0 gives a single pattern.
- R7: Output bits whose mask bit is 0 do not change at any point during a record's run.
- R8: While the generator waits for the next record, patValid is low and pattern keeps the last pattern of the previous record, however long the wait lasts.
- R9: The cycle after the final pattern of a record tagged seedLast, done is high for exactly one cycle. The generator is then idle, with seedReady low.
- R10: A start pulse is ignored while a run is in progress. A start pulse after done begins a new session.
- R11: seedValid is ignored while seedReady is low. No record is taken and patValid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that arms the generator when it is idle |
| seedValid | input | 1 | Seed record present on the seed inputs |
| seedReady | output | 1 | Generator is waiting for a record |
| seedConst | input | N_IN | Constant values for inputs that are not counted |
| seedMask | input | N_IN | 1 selects the counter for that input |
| seedSel | input | N_IN*IDX_W | Counter bit index for each input |
| seedStart | input | K_BITS | Gray start code of the run |
| seedLen | input | LEN_W | Run length minus one |
| seedLast | input | 1 | Marks the final record of the session |
| patValid | output | 1 | pattern holds a test pattern this cycle |
| pattern | output | N_IN | Pattern driven to the circuit under test |
| done | output | 1 | One-cycle pulse after the final run ends |

## Verification
A wrong binary count or a faulty Gray conversion shows up in the first pattern of a record, or at the latest on the next pattern, as a counted bit with the wrong value. A run-length counter that is off by one shows as patValid lasting one cycle too long or too short at the end of the record. A mux select that is misrouted shows as soon as a record maps its counted inputs in a non-identity order. A counter that is not frozen shows as a changed pattern during the wait between records, in the first cycle of that wait.

// File: rtl/gray_tpg_pkg.sv
package gray_tpg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } tpgState_e;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } tpgStrobe_t;

endpackage

// File: rtl/gray_tpg_ctrl.sv
module gray_tpg_ctrl
  import gray_tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       seedValid,
  input  logic       runEnd,
  input  logic       lastSeed,
  output tpgStrobe_t strobe,
  output logic       seedReady,
  output logic       patValid,
  output logic       done
);

  tpgState_e state, stateNext;
  logic      doneReg;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start)     stateNext = ST_WAIT;
      ST_WAIT: if (seedValid) stateNext = ST_RUN;
      ST_RUN:  if (runEnd)    stateNext = lastSeed ? ST_IDLE : ST_WAIT;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_RUN) && runEnd && lastSeed;
    end
  end

  assign strobe.loadSeed = (state == ST_WAIT) && seedValid;
  assign strobe.advance  = (state == ST_RUN) && !runEnd;
  assign seedReady       = (state == ST_WAIT);
  assign patValid        = (state == ST_RUN);
  assign done            = doneReg;

  // R2
  handshake_starts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seedValid && seedReady) |=> patValid);

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!seedReady && !patValid));

  // R11
  no_take_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seedReady && !patValid) |=> !patValid);

endmodule

// File: rtl/gray_tpg_dp.sv
module gray_tpg_dp
  import gray_tpg_pkg::*;
#(
  parameter int N_IN   = 12,
  parameter int K_BITS = 4,
  parameter int LEN_W  = 8,
  localparam int IDX_W = (K_BITS > 1) ? $clog2(K_BITS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tpgStrobe_t              strobe,
  input  logic [N_IN-1:0]         seedConst,
  input  logic [N_IN-1:0]         seedMask,
  input  logic [N_IN*IDX_W-1:0]   seedSel,
  input  logic [K_BITS-1:0]       seedStart,
  input  logic [LEN_W-1:0]        seedLen,
  input  logic                    seedLast,
  output logic                    runEnd,
  output logic                    lastSeed,
  output logic [N_IN-1:0]         pattern
);

  logic [N_IN-1:0]       constReg;
  logic [N_IN-1:0]       maskReg;
  logic [N_IN*IDX_W-1:0] selReg;
  logic [K_BITS-1:0]     binCnt;
  logic [LEN_W-1:0]      remaining;
  logic                  lastReg;
  logic [K_BITS-1:0]     grayNow;
  logic [K_BITS-1:0]     startBin;

  // Gray start code to binary count: prefix XOR from the top bit down
  always_comb begin
    startBin[K_BITS-1] = seedStart[K_BITS-1];
    for (int b = K_BITS - 2; b >= 0; b--) begin
      startBin[b] = startBin[b+1] ^ seedStart[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      constReg  <= '0;
      maskReg   <= '0;
      selReg    <= '0;
      binCnt    <= '0;
      remaining <= '0;
      lastReg   <= 1'b0;
    end else if (strobe.loadSeed) begin
      constReg  <= seedConst;
      maskReg   <= seedMask;
      selReg    <= seedSel;
      binCnt    <= startBin;
      remaining <= seedLen;
      lastReg   <= seedLast;
    end else if (strobe.advance) begin
      binCnt    <= binCnt + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  assign grayNow  = binCnt ^ (binCnt >> 1);
  assign runEnd   = (remaining == '0);
  assign lastSeed = lastReg;

  // One test-path mux per input: seed constant or a selected counter bit
  for (genvar i = 0; i < N_IN; i++) begin : g_inMux
    logic [IDX_W-1:0] selIdx;
    logic             cntBit;
    assign selIdx     = selReg[i*IDX_W +: IDX_W];
    assign cntBit     = (int'(selIdx) < K_BITS) ? grayNow[selIdx] : 1'b0;
    assign pattern[i] = maskReg[i] ? cntBit : constReg[i];
  end

  // R4
  gray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> ($countones(grayNow ^ $past(grayNow)) == 1));

  // R7
  const_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> (((pattern ^ $past(pattern)) & ~maskReg) == '0));

  // R8
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.loadSeed || strobe.advance) |=> $stable(pattern));

  // R6
  length_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> (remaining == $past(remaining) - 1'b1));

endmodule

// File: rtl/gray_tpg.sv
module gray_tpg
  import gray_tpg_pkg::*;
#(
  parameter int N_IN   = 12,
  parameter int K_BITS = 4,
  parameter int LEN_W  = 8,
  localparam int IDX_W = (K_BITS > 1) ? $clog2(K_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  seedValid,
  output logic                  seedReady,
  input  logic [N_IN-1:0]       seedConst,
  input  logic [N_IN-1:0]       seedMask,
  input  logic [N_IN*IDX_W-1:0] seedSel,
  input  logic [K_BITS-1:0]     seedStart,
  input  logic [LEN_W-1:0]      seedLen,
  input  logic                  seedLast,
  output logic                  patValid,
  output logic [N_IN-1:0]       pattern,
  output logic                  done
);

  tpgStrobe_t strobe;
  logic       runEnd;
  logic       lastSeed;

  gray_tpg_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .seedValid (seedValid),
    .runEnd    (runEnd),
    .lastSeed  (lastSeed),
    .strobe    (strobe),
    .seedReady (seedReady),
    .patValid  (patValid),
    .done      (done)
  );

  gray_tpg_dp #(
    .N_IN   (N_IN),
    .K_BITS (K_BITS),
    .LEN_W  (LEN_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .seedConst (seedConst),
    .seedMask  (seedMask),
    .seedSel   (seedSel),
    .seedStart (seedStart),
    .seedLen   (seedLen),
    .seedLast  (seedLast),
    .runEnd    (runEnd),
    .lastSeed  (lastSeed),
    .pattern   (pattern)
  );

endmodule

// File: tb/gray_tpg_tb.sv
module gray_tpg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 12;
  localparam int K  = 4;
  localparam int IW = 2;
  localparam int LW = 8;

  typedef struct packed {
    logic [N-1:0]    c;
    logic [N-1:0]    m;
    logic [N*IW-1:0] s;
    logic [K-1:0]    st;
    logic [LW-1:0]   len;
    logic            last;
  } seedRec_t;

  // const, mask, selectors, Gray start, length-1, last
  localparam seedRec_t TABLE [4] = '{
    '{12'hA5C, 12'h00F, 24'h0000E4, 4'b0000, 8'd5, 1'b0},
    '{12'h3C3, 12'hF00, 24'h1B0000, 4'b1010, 8'd9, 1'b0},
    '{12'hFFF, 12'h249, 24'h0C2040, 4'b1000, 8'd2, 1'b0},
    '{12'h0F0, 12'h000, 24'h000000, 4'b0000, 8'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic seedValid = 1'b0;
  logic seedReady;
  logic [N-1:0] seedConst = '0;
  logic [N-1:0] seedMask = '0;
  logic [N*IW-1:0] seedSel = '0;
  logic [K-1:0] seedStart = '0;
  logic [LW-1:0] seedLen = '0;
  logic seedLast = 1'b0;
  logic patValid;
  logic [N-1:0] pattern;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] lastPat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_tpg #(.N_IN(N), .K_BITS(K), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .seedValid(seedValid), .seedReady(seedReady),
    .seedConst(seedConst), .seedMask(seedMask), .seedSel(seedSel),
    .seedStart(seedStart), .seedLen(seedLen), .seedLast(seedLast),
    .patValid(patValid), .pattern(pattern), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [K-1:0] toBin(input logic [K-1:0] g);
    logic [K-1:0] b;
    b = '0;
    for (int i = K - 1; i >= 0; i--) b[i] = ((i == K - 1) ? 1'b0 : b[i+1]) ^ g[i];
    return b;
  endfunction

  function automatic logic [N-1:0] model(input seedRec_t r, input logic [K-1:0] g);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx  = int'(r.s[i*IW +: IW]);
      p[i] = r.m[i] ? g[idx] : r.c[i];
    end
    return p;
  endfunction

  // Offers record r after waitCyc idle cycles, then checks its whole run
  task automatic runSeed(input seedRec_t r, input int waitCyc, input bit checkFreeze);
    logic [K-1:0] b;
    logic [K-1:0] g;
    for (int w = 0; w < waitCyc; w++) begin
      check(patValid == 1'b0, "R8 patValid low while waiting", patValid, 0);
      if (checkFreeze) check(pattern == lastPat, "R8 pattern frozen", pattern, lastPat);
      @(negedge clk);
    end
    check(seedReady == 1'b1, "R2 seedReady in wait", seedReady, 1);
    seedConst = r.c; seedMask = r.m; seedSel = r.s;
    seedStart = r.st; seedLen = r.len; seedLast = r.last;
    seedValid = 1'b1;
    @(negedge clk);
    seedValid = 1'b0;
    b = toBin(r.st);
    for (int j = 0; j <= int'(r.len); j++) begin
      g = b ^ (b >> 1);
      check(patValid == 1'b1, "R6 patValid during run", patValid, 1);
      check(pattern == model(r, g), "R3 R4 R5 pattern", pattern, model(r, g));
      check((pattern & ~r.m) == (r.c & ~r.m), "R7 constant bits", pattern & ~r.m, r.c & ~r.m);
      lastPat = pattern;
      b = b + 1'b1;
      @(negedge clk);
    end
    check(patValid == 1'b0, "R6 run ends after L+1", patValid, 0);
    if (r.last) begin
      check(done == 1'b1, "R9 done after final run", done, 1);
      check(seedReady == 1'b0, "R9 idle after final", seedReady, 0);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
    end else begin
      check(seedReady == 1'b1, "R2 ready for next seed", seedReady, 1);
      check(pattern == lastPat, "R8 pattern frozen", pattern, lastPat);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seedRec_t d;
    repeat (3) @(negedge clk);
    // R1
    check(patValid == 1'b0, "R1 patValid reset", patValid, 0);
    check(seedReady == 1'b0, "R1 seedReady reset", seedReady, 0);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(pattern == '0, "R1 pattern reset", pattern, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: a record offered while idle is not taken
    seedValid = 1'b1; seedConst = 12'h111; seedLen = 8'd0; seedLast = 1'b1;
    repeat (3) @(negedge clk);
    check(seedReady == 1'b0, "R11 ready low in idle", seedReady, 0);
    check(patValid == 1'b0, "R11 record ignored", patValid, 0);
    seedValid = 1'b0;

    // Session 1: table walk with varied waits
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int t = 0; t < 4; t++) runSeed(TABLE[t], (t == 0) ? 0 : 2 * t + 1, t != 0);

    // R10: new session, start pulses during the run are ignored
    d = '{12'h5A5, 12'h030, 24'h000B00, 4'b0110, 8'd3, 1'b1};
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(seedReady == 1'b1, "R10 restart after done", seedReady, 1);
    fork
      runSeed(d, 0, 1'b0);
      begin
        repeat (2) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    join
    @(negedge clk);
    check(seedReady == 1'b0, "R10 start during run ignored", seedReady, 0);
    check(patValid == 1'b0, "R10 stays idle", patValid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule